// File: doc/BRIEF.md
# Station-Address Receive Filter

This block sits between a frame decoder and the host receive path of a serial terminal link. The decoder reports two things: the start and end of each message, and each decoded frame with its 3-bit station address, 8-bit data byte and an error indication. The filter tracks whether the current frame is the first one of a message. It then decides whether that frame is handed to the host. The block also conditions the raw line bit for the decoder, optionally inverting it.

In promiscuous mode every frame of an active message is handed on. In addressed mode only the first frame is compared with a locally programmed station address.
- A match, or a first frame that carries an error, opens the message: every later frame passes without any further compare.
- A clean mismatch sends the block straight back to hunting for the next message start, and nothing is handed on.

Each forwarded frame is latched into a one-entry holding register. That register shows the received address, the data byte and the error flag, and raises a data-available flag until the host reads it.

The state machine has three states:
- **HUNT**: idle, waiting for a message start. Frames are ignored.
- **FIRST**: the next frame is the first frame of the message and is address-checked.
- **PASS**: every frame is forwarded.

It has these transitions:
- HUNT→FIRST on a start pulse.
- FIRST→PASS on a forwarded first frame.
- FIRST→HUNT on a clean mismatch or on an end pulse.
- PASS→HUNT on an end pulse.

Top module: `stn_rx_filter`

## Requirements
- R1: After reset, `active_o`, `first_o`, `avail_o`, `fwd_push_o` and `stat_err_o` are 0, and `stat_addr_o` and `data_o` are all zeros.
- R2: In HUNT, a `msg_start_i` pulse raises `active_o` and `first_o` one cycle later. Frames arriving while in HUNT produce no push and leave the holding register unchanged.
- R3: With `promisc_i` = 1, any frame in FIRST or PASS is forwarded: one cycle later `fwd_push_o` pulses, `avail_o` = 1, and `stat_addr_o`, `data_o` and `stat_err_o` carry the frame's address, data and error bit.
- R4: With `promisc_i` = 0, a first frame whose address equals `my_addr_i` is forwarded, and the block moves to PASS (`first_o` = 0, `active_o` = 1).
- R5: In PASS, every frame is forwarded whatever its address.
- R6: With `promisc_i` = 0, an error-free first frame whose address differs from `my_addr_i` is not forwarded, and the block returns to HUNT (`active_o` = 0) the next cycle. Later frames are then ignored until a new start.
- R7: A first frame with `frm_err_i` = 1 is forwarded with `stat_err_o` = 1 even on an address mismatch, and the block moves to PASS.
- R8: `msg_end_i` sends the block to HUNT one cycle later. A frame in the same cycle is still judged by the current state.
- R9: A `host_rd_i` pulse with no frame forwarded in the same cycle clears `avail_o` and `stat_err_o` one cycle later. `stat_addr_o` and `data_o` hold their values.
- R10: A forwarded frame overwrites the holding register even when `avail_o` is already 1, and wins over a `host_rd_i` in the same cycle, leaving `avail_o` = 1.
- R11: `line_dec_o` equals `line_raw_i` when `rx_inv_i` = 0 and its complement when `rx_inv_i` = 1, with no clock delay.
- R12: A `msg_start_i` pulse while already in FIRST or PASS is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_raw_i | input | 1 | Raw line bit from the line interface |
| rx_inv_i | input | 1 | Invert the line bit toward the decoder |
| line_dec_o | output | 1 | Conditioned line bit to the decoder |
| promisc_i | input | 1 | 1 = forward all frames, 0 = addressed mode |
| my_addr_i | input | ADDR_W | Local station address |
| msg_start_i | input | 1 | Valid start sequence seen (pulse) |
| msg_end_i | input | 1 | Message ended / line idle (pulse) |
| frm_valid_i | input | 1 | A decoded frame is presented (pulse) |
| frm_addr_i | input | ADDR_W | Station address field of the frame |
| frm_data_i | input | DATA_W | Data byte of the frame |
| frm_err_i | input | 1 | Frame carries a receive error |
| host_rd_i | input | 1 | Host reads the data byte (pulse) |
| fwd_push_o | output | 1 | One-cycle pulse per forwarded frame |
| avail_o | output | 1 | Data available in the holding register |
| stat_addr_o | output | ADDR_W | Address of the held frame |
| stat_err_o | output | 1 | Error flag of the held frame |
| data_o | output | DATA_W | Data byte of the held frame |
| active_o | output | 1 | Receiver is in FIRST or PASS |
| first_o | output | 1 | Next frame is the first of the message |

## Verification
Every registered result is due exactly one clock edge after the cycle in which its stimulus is presented. This covers the state flags, the push pulse, the holding register and the clearing on a read. `line_dec_o` is combinational and is due in the same cycle. The bench applies each stimulus vector just after a falling edge and compares the expected outputs at the next falling edge, so one rising edge lies between stimulus and check. For the line inversion, it compares a short settling delay after changing the inputs.

// File: rtl/stn_rx_filter_pkg.sv
package stn_rx_filter_pkg;

    // Message-tracking states of the receive filter
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FIRST = 2'd1,
        ST_PASS  = 2'd2
    } rxf_state_e;

endpackage

// File: rtl/rxf_line_cond.sv
// Optional inversion of the raw line bit before it reaches the decoder.
module rxf_line_cond #(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0] raw_i,
    input  logic             inv_i,
    output logic [LANES-1:0] cond_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cond_o[g] = inv_i ? ~raw_i[g] : raw_i[g];
    end
endmodule

// File: rtl/rxf_addr_cmp.sv
// Bitwise station-address equality compare.
module rxf_addr_cmp #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] bit_eq;

    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        assign bit_eq[g] = ~(rx_addr_i[g] ^ own_addr_i[g]);
    end

    assign hit_o = &bit_eq;
endmodule

// File: rtl/rxf_msg_fsm.sv
// First-frame tracking and forward/discard decision.
module rxf_msg_fsm
    import stn_rx_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       promisc_i,
    input  logic       addr_hit_i,
    input  logic       msg_start_i,
    input  logic       msg_end_i,
    input  logic       frm_valid_i,
    input  logic       frm_err_i,
    output logic       fwd_o,
    output rxf_state_e state_o
);
    rxf_state_e state_q;
    rxf_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and forward decision
    always_comb begin
        state_d = state_q;
        fwd_o   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                // frames are ignored while hunting
                if (msg_start_i) begin
                    state_d = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (frm_valid_i) begin
                    if (promisc_i || addr_hit_i || frm_err_i) begin
                        fwd_o   = 1'b1;
                        state_d = ST_PASS;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                if (msg_end_i) begin
                    state_d = ST_HUNT;
                end
            end
            ST_PASS: begin
                if (frm_valid_i) begin
                    fwd_o = 1'b1;
                end
                if (msg_end_i) begin
                    state_d = ST_HUNT;
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rxf_hold_reg.sv
// One-entry holding register toward the host, with data-available flag.
module rxf_hold_reg #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              err_i,
    output logic              push_o,
    output logic              avail_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_o  <= 1'b0;
            avail_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
            err_o   <= 1'b0;
        end else begin
            push_o <= load_i;
            if (load_i) begin
                avail_o <= 1'b1;
                addr_o  <= addr_i;
                data_o  <= data_i;
                err_o   <= err_i;
            end else if (rd_i) begin
                avail_o <= 1'b0;
                err_o   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/stn_rx_filter.sv
// Station-address receive filter: top level.
module stn_rx_filter
    import stn_rx_filter_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_raw_i,
    input  logic              rx_inv_i,
    output logic              line_dec_o,
    input  logic              promisc_i,
    input  logic [ADDR_W-1:0] my_addr_i,
    input  logic              msg_start_i,
    input  logic              msg_end_i,
    input  logic              frm_valid_i,
    input  logic [ADDR_W-1:0] frm_addr_i,
    input  logic [DATA_W-1:0] frm_data_i,
    input  logic              frm_err_i,
    input  logic              host_rd_i,
    output logic              fwd_push_o,
    output logic              avail_o,
    output logic [ADDR_W-1:0] stat_addr_o,
    output logic              stat_err_o,
    output logic [DATA_W-1:0] data_o,
    output logic              active_o,
    output logic              first_o
);
    logic       addr_hit;
    logic       fwd;
    rxf_state_e state;

    rxf_line_cond #(.LANES(1)) u_line (
        .raw_i  (line_raw_i),
        .inv_i  (rx_inv_i),
        .cond_o (line_dec_o)
    );

    rxf_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .rx_addr_i  (frm_addr_i),
        .own_addr_i (my_addr_i),
        .hit_o      (addr_hit)
    );

    rxf_msg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .promisc_i   (promisc_i),
        .addr_hit_i  (addr_hit),
        .msg_start_i (msg_start_i),
        .msg_end_i   (msg_end_i),
        .frm_valid_i (frm_valid_i),
        .frm_err_i   (frm_err_i),
        .fwd_o       (fwd),
        .state_o     (state)
    );

    rxf_hold_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (fwd),
        .rd_i    (host_rd_i),
        .addr_i  (frm_addr_i),
        .data_i  (frm_data_i),
        .err_i   (frm_err_i),
        .push_o  (fwd_push_o),
        .avail_o (avail_o),
        .addr_o  (stat_addr_o),
        .data_o  (data_o),
        .err_o   (stat_err_o)
    );

    assign active_o = (state != ST_HUNT);
    assign first_o  = (state == ST_FIRST);
endmodule

// File: rtl/stn_rx_filter_chk.sv
// Protocol checker, bound to the filter top.
module stn_rx_filter_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              promisc_i,
    input logic [ADDR_W-1:0] my_addr_i,
    input logic              msg_start_i,
    input logic              msg_end_i,
    input logic              frm_valid_i,
    input logic [ADDR_W-1:0] frm_addr_i,
    input logic              frm_err_i,
    input logic              host_rd_i,
    input logic              fwd_push_o,
    input logic              avail_o,
    input logic              stat_err_o,
    input logic              active_o,
    input logic              first_o
);
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && msg_start_i) |=> (first_o && active_o));

    assert_hunt_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && frm_valid_i) |=> !fwd_push_o);

    assert_promisc_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && promisc_i && frm_valid_i) |=> fwd_push_o);

    assert_later_frames_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !first_o && frm_valid_i) |=> fwd_push_o);

    assert_mismatch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (first_o && frm_valid_i && !promisc_i && !frm_err_i && (frm_addr_i != my_addr_i))
        |=> (!fwd_push_o && !active_o));

    assert_err_first_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (first_o && frm_valid_i && frm_err_i) |=> (fwd_push_o && stat_err_o && !first_o));

    assert_end_to_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_end_i |=> !active_o);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !frm_valid_i) |=> (!avail_o && !stat_err_o));

    assert_push_sets_avail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_push_o |-> avail_o);

    assert_restart_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !first_o && msg_start_i && !msg_end_i && !frm_valid_i) |=> !first_o);
endmodule

bind stn_rx_filter stn_rx_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .promisc_i   (promisc_i),
    .my_addr_i   (my_addr_i),
    .msg_start_i (msg_start_i),
    .msg_end_i   (msg_end_i),
    .frm_valid_i (frm_valid_i),
    .frm_addr_i  (frm_addr_i),
    .frm_err_i   (frm_err_i),
    .host_rd_i   (host_rd_i),
    .fwd_push_o  (fwd_push_o),
    .avail_o     (avail_o),
    .stat_err_o  (stat_err_o),
    .active_o    (active_o),
    .first_o     (first_o)
);

// File: tb/stn_rx_filter_test.sv
module stn_rx_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 20;

    typedef struct packed {
        logic       st;
        logic       en;
        logic       v;
        logic       p;
        logic [2:0] a;
        logic [7:0] d;
        logic       e;
        logic       rd;
        logic       x_push;
        logic       x_avail;
        logic       x_act;
        logic       x_first;
        logic [2:0] x_addr;
        logic [7:0] x_data;
        logic       x_err;
        logic [7:0] req;
    } vec_t;

    // Stimulus / expected vectors; own station address is 5 throughout.
    localparam vec_t VEC [NVEC] = '{
        // st en v  p  a     d      e  rd | push av act fst addr  data   err  req
        '{1'b0,1'b0,1'b1,1'b0,3'd5,8'hAA,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0, 8'd2},  // R2 frame in hunt
        '{1'b1,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,3'd0,8'h00,1'b0, 8'd2},  // R2 start
        '{1'b0,1'b0,1'b1,1'b0,3'd5,8'h3C,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0,3'd5,8'h3C,1'b0, 8'd4},  // R4 match
        '{1'b0,1'b0,1'b1,1'b0,3'd2,8'h11,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0,3'd2,8'h11,1'b0, 8'd5},  // R5 later frame
        '{1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0,3'd2,8'h11,1'b0, 8'd9},  // R9 read
        '{1'b0,1'b1,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd2,8'h11,1'b0, 8'd8},  // R8 end
        '{1'b1,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,3'd2,8'h11,1'b0, 8'd2},  // R2 start
        '{1'b0,1'b0,1'b1,1'b0,3'd3,8'h77,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd2,8'h11,1'b0, 8'd6},  // R6 mismatch
        '{1'b0,1'b0,1'b1,1'b0,3'd5,8'h55,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd2,8'h11,1'b0, 8'd6},  // R6 ignored after
        '{1'b1,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1,3'd2,8'h11,1'b0, 8'd2},  // R2 start
        '{1'b0,1'b0,1'b1,1'b0,3'd1,8'h0F,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0,3'd1,8'h0F,1'b1, 8'd7},  // R7 err first
        '{1'b0,1'b0,1'b1,1'b0,3'd6,8'hF0,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b0,3'd6,8'hF0,1'b0, 8'd10}, // R10 frame beats read
        '{1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0,3'd6,8'hF0,1'b0, 8'd9},  // R9 read
        '{1'b0,1'b1,1'b1,1'b0,3'd4,8'h99,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0,3'd4,8'h99,1'b0, 8'd8},  // R8 frame with end
        '{1'b1,1'b0,1'b0,1'b1,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1,3'd4,8'h99,1'b0, 8'd2},  // R2 start
        '{1'b0,1'b0,1'b1,1'b1,3'd0,8'hC3,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0,3'd0,8'hC3,1'b0, 8'd3},  // R3 promisc first
        '{1'b0,1'b0,1'b1,1'b1,3'd7,8'h81,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0,3'd7,8'h81,1'b1, 8'd3},  // R3 promisc err
        '{1'b1,1'b0,1'b0,1'b1,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b0,3'd7,8'h81,1'b1, 8'd12}, // R12 restart ignored
        '{1'b0,1'b0,1'b0,1'b1,3'd0,8'h00,1'b0,1'b1, 1'b0,1'b0,1'b1,1'b0,3'd7,8'h81,1'b0, 8'd9},  // R9 read
        '{1'b0,1'b1,1'b0,1'b1,3'd0,8'h00,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd7,8'h81,1'b0, 8'd8}   // R8 end
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_raw_i = 1'b0;
    logic       rx_inv_i = 1'b0;
    logic       line_dec_o;
    logic       promisc_i = 1'b0;
    logic [2:0] my_addr_i = 3'd5;
    logic       msg_start_i = 1'b0;
    logic       msg_end_i = 1'b0;
    logic       frm_valid_i = 1'b0;
    logic [2:0] frm_addr_i = '0;
    logic [7:0] frm_data_i = '0;
    logic       frm_err_i = 1'b0;
    logic       host_rd_i = 1'b0;
    logic       fwd_push_o;
    logic       avail_o;
    logic [2:0] stat_addr_o;
    logic       stat_err_o;
    logic [7:0] data_o;
    logic       active_o;
    logic       first_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stn_rx_filter #(.ADDR_W(3), .DATA_W(8)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_raw_i  (line_raw_i),
        .rx_inv_i    (rx_inv_i),
        .line_dec_o  (line_dec_o),
        .promisc_i   (promisc_i),
        .my_addr_i   (my_addr_i),
        .msg_start_i (msg_start_i),
        .msg_end_i   (msg_end_i),
        .frm_valid_i (frm_valid_i),
        .frm_addr_i  (frm_addr_i),
        .frm_data_i  (frm_data_i),
        .frm_err_i   (frm_err_i),
        .host_rd_i   (host_rd_i),
        .fwd_push_o  (fwd_push_o),
        .avail_o     (avail_o),
        .stat_addr_o (stat_addr_o),
        .stat_err_o  (stat_err_o),
        .data_o      (data_o),
        .active_o    (active_o),
        .first_o     (first_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        msg_start_i = 1'b0; msg_end_i = 1'b0; frm_valid_i = 1'b0;
        frm_addr_i = '0; frm_data_i = '0; frm_err_i = 1'b0; host_rd_i = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        check(tag, "active", {31'd0, active_o}, 32'd0);
        check(tag, "first", {31'd0, first_o}, 32'd0);
        check(tag, "avail", {31'd0, avail_o}, 32'd0);
        check(tag, "push", {31'd0, fwd_push_o}, 32'd0);
        check(tag, "err", {31'd0, stat_err_o}, 32'd0);
        check(tag, "addr", {29'd0, stat_addr_o}, 32'd0);
        check(tag, "data", {24'd0, data_o}, 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: drive at a falling edge, compare at the next one.
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d(vec%0d)", VEC[i].req, i);
            msg_start_i = VEC[i].st;
            msg_end_i   = VEC[i].en;
            frm_valid_i = VEC[i].v;
            promisc_i   = VEC[i].p;
            frm_addr_i  = VEC[i].a;
            frm_data_i  = VEC[i].d;
            frm_err_i   = VEC[i].e;
            host_rd_i   = VEC[i].rd;
            @(negedge clk);
            check(tag, "push",   {31'd0, fwd_push_o}, {31'd0, VEC[i].x_push});
            check(tag, "avail",  {31'd0, avail_o},    {31'd0, VEC[i].x_avail});
            check(tag, "active", {31'd0, active_o},   {31'd0, VEC[i].x_act});
            check(tag, "first",  {31'd0, first_o},    {31'd0, VEC[i].x_first});
            check(tag, "addr",   {29'd0, stat_addr_o},{29'd0, VEC[i].x_addr});
            check(tag, "data",   {24'd0, data_o},     {24'd0, VEC[i].x_data});
            check(tag, "err",    {31'd0, stat_err_o}, {31'd0, VEC[i].x_err});
        end
        drive_idle();
        promisc_i = 1'b0;

        // R11: line inversion, combinational
        for (int k = 0; k < 4; k++) begin
            line_raw_i = k[0];
            rx_inv_i   = k[1];
            #1;
            check("R11", "line_dec", {31'd0, line_dec_o}, {31'd0, k[0] ^ k[1]});
        end

        // R6: a different own address, clean mismatch then hunt
        my_addr_i = 3'd2;
        @(negedge clk);
        msg_start_i = 1'b1;
        @(negedge clk);
        msg_start_i = 1'b0;
        frm_valid_i = 1'b1; frm_addr_i = 3'd5; frm_data_i = 8'h5A;
        @(negedge clk);
        drive_idle();
        check("R6", "push", {31'd0, fwd_push_o}, 32'd0);
        check("R6", "active", {31'd0, active_o}, 32'd0);

        // R4: same own address matches
        msg_start_i = 1'b1;
        @(negedge clk);
        msg_start_i = 1'b0;
        frm_valid_i = 1'b1; frm_addr_i = 3'd2; frm_data_i = 8'hE7;
        @(negedge clk);
        drive_idle();
        check("R4", "push", {31'd0, fwd_push_o}, 32'd1);
        check("R4", "data", {24'd0, data_o}, 32'hE7);
        check("R4", "first", {31'd0, first_o}, 32'd0);

        // R8: end while in FIRST
        msg_end_i = 1'b1;
        @(negedge clk);
        msg_end_i = 1'b0;
        msg_start_i = 1'b1;
        @(negedge clk);
        msg_start_i = 1'b0;
        msg_end_i = 1'b1;
        @(negedge clk);
        msg_end_i = 1'b0;
        check("R8", "active", {31'd0, active_o}, 32'd0);

        // R1: reset in mid-message clears everything
        msg_start_i = 1'b1;
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        #1;
        check_reset_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule